// File: doc/BRIEF.md
# Rotating Priority Interrupt Vector Arbiter

This block merges the interrupt requests of four serial channels into one interrupt line toward the host. When the host runs an interrupt-select (acknowledge) cycle, the block picks one requesting channel and places that channel's 8-bit vector on the read data. Each vector comes from the channel's scratchpad register, so the host can give every channel a different vector by writing those registers.

Priority rotates. A pointer names the channel with the highest priority, and the search for a requester runs upward from the pointer, wrapping around. After a grant, the pointer moves to the channel just past the one serviced. That channel now sits first in the order and the serviced one sits last. A channel that keeps requesting therefore cannot shut out the others. Clearing a request stays inside each channel and is outside this block.

An acknowledge cycle is a level strobe held high for one or more clocks. The clock edge that first sees the strobe high samples the requests and the vectors. The result is held until the next acknowledge cycle.

Top module: `irq_vec_arbiter`

## Requirements
- R1: `irq_o` is high in the same cycle whenever any bit of `irq_req_i` is high, and low when all are low.
- R2: After reset, `grant_vld_o` is 0, `grant_id_o` is 0, `vec_o` is 8'hFF, and channel 0 has the highest priority.
- R3: The clock edge at which `ack_i` is first seen high after being low samples the requests and updates the outputs. The outputs then hold their values while `ack_i` stays high, and until the next acknowledge cycle starts.
- R4: The granted channel is the first requesting channel found by searching upward from the priority pointer and wrapping from 3 back to 0. `grant_id_o` gives its number (0 to 3) and `grant_vld_o` is set to 1.
- R5: After channel g is granted, the pointer becomes (g+1) mod 4. Channel g is then lowest priority and channel (g+1) mod 4 is highest.
- R6: `vec_o` returns the granted channel's vector as sampled at the start edge. Channel k's vector sits at bits [8k+7:8k] of `vec_i`.
- R7: An acknowledge cycle that finds no request returns `vec_o` = 8'hFF with `grant_vld_o` = 0, and leaves the priority pointer unchanged.
- R8: While all four channels request continuously, successive acknowledge cycles grant channels in strictly incrementing circular order.
- R9: Changes on `irq_req_i` or `vec_i` after the start edge, during the same acknowledge cycle, do not change `vec_o`, `grant_id_o` or `grant_vld_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 4 | Per-channel interrupt requests, bit k from channel k |
| vec_i | input | 32 | Per-channel scratchpad vectors, channel k at [8k+7:8k] |
| ack_i | input | 1 | Interrupt-select (acknowledge) strobe, level |
| irq_o | output | 1 | Combined interrupt toward the host |
| vec_o | output | 8 | Vector returned on the select cycle |
| grant_id_o | output | 2 | Number of the granted channel |
| grant_vld_o | output | 1 | Last select cycle granted a channel |

## Verification
The embedded properties check on every cycle that the held result stays stable during an acknowledge cycle. They also check that a granted channel was really requesting at the start edge, that the pointer lands just past the grant, and that an empty acknowledge returns 8'hFF without moving the pointer. Only the bench scenarios show which channel wins for a given pointer and request pattern. They do this by sweeping all sixteen request patterns across every pointer position the rotation reaches. The bench also shows that vectors are routed from the correct byte lanes and that the round-robin grant order appears under continuous requests.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   // circular increment of a channel index
   function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction

   // circular add of an offset to a base index
   function automatic int unsigned wrap_add(input int unsigned base, input int unsigned off,
                                            input int unsigned n);
      return (base + off >= n) ? base + off - n : base + off;
   endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick
   import irq_arb_pkg::*;
#(
   parameter int N_CH = 4,
   localparam int IDW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [N_CH-1:0] req_i,
   input  logic [IDW-1:0]  ptr_i,
   output logic            any_o,
   output logic [IDW-1:0]  pick_o
);

   always_comb begin
      pick_o = '0;
      // descending offset so the smallest offset from the pointer wins
      for (int k = N_CH - 1; k >= 0; k--) begin
         if (req_i[wrap_add(int'(ptr_i), k, N_CH)])
            pick_o = IDW'(wrap_add(int'(ptr_i), k, N_CH));
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/vec_sel.sv
module vec_sel #(
   parameter int N_CH  = 4,
   parameter int VEC_W = 8,
   localparam int IDW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [N_CH*VEC_W-1:0] flat_i,
   input  logic [IDW-1:0]        sel_i,
   output logic [VEC_W-1:0]      vec_o
);

   logic [VEC_W-1:0] lanes [N_CH];

   for (genvar g = 0; g < N_CH; g++) begin : g_lane
      assign lanes[g] = flat_i[g*VEC_W +: VEC_W];
   end

   assign vec_o = lanes[sel_i];

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
   import irq_arb_pkg::*;
#(
   parameter int              N_CH     = 4,
   parameter int              VEC_W    = 8,
   parameter logic [VEC_W-1:0] EMPTY_VEC = '1,
   localparam int IDW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_CH-1:0]       irq_req_i,
   input  logic [N_CH*VEC_W-1:0] vec_i,
   input  logic                  ack_i,
   output logic                  irq_o,
   output logic [VEC_W-1:0]      vec_o,
   output logic [IDW-1:0]        grant_id_o,
   output logic                  grant_vld_o
);

   // elaboration-time configuration checks
   if (N_CH < 2) begin : g_bad_ch
      $error("irq_vec_arbiter: N_CH must be at least 2");
   end
   if ((1 << IDW) != N_CH) begin : g_bad_pow
      $error("irq_vec_arbiter: N_CH must be a power of two");
   end
   if (VEC_W < 1) begin : g_bad_w
      $error("irq_vec_arbiter: VEC_W must be positive");
   end

   logic             ack_q;
   logic [IDW-1:0]   ptr_q;
   logic [IDW-1:0]   gid_q;
   logic             gvld_q;
   logic [VEC_W-1:0] vec_q;

   logic             start;
   logic             any_req;
   logic [IDW-1:0]   pick;
   logic [VEC_W-1:0] lane_vec;

   assign start = ack_i & ~ack_q;
   assign irq_o = any_req;

   rr_pick #(.N_CH(N_CH)) pick_i (
      .req_i  (irq_req_i),
      .ptr_i  (ptr_q),
      .any_o  (any_req),
      .pick_o (pick)
   );

   vec_sel #(.N_CH(N_CH), .VEC_W(VEC_W)) sel_i (
      .flat_i (vec_i),
      .sel_i  (pick),
      .vec_o  (lane_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q  <= 1'b0;
         ptr_q  <= '0;
         gid_q  <= '0;
         gvld_q <= 1'b0;
         vec_q  <= EMPTY_VEC;
      end else begin
         ack_q <= ack_i;
         if (start) begin
            if (any_req) begin
               gid_q  <= pick;
               gvld_q <= 1'b1;
               vec_q  <= lane_vec;
               ptr_q  <= IDW'(wrap_inc(int'(pick), N_CH));
            end else begin
               gvld_q <= 1'b0;
               vec_q  <= EMPTY_VEC;
            end
         end
      end
   end

   assign vec_o       = vec_q;
   assign grant_id_o  = gid_q;
   assign grant_vld_o = gvld_q;

   // R3: result held while the acknowledge level persists
   a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_q && ack_i) |=> ($stable(vec_o) && $stable(grant_id_o) && $stable(grant_vld_o)));

   // R4: a granted channel was requesting at the start edge
   a_r4_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (start && any_req) |=>
         (grant_vld_o && ((($past(irq_req_i) >> grant_id_o) & {{(N_CH-1){1'b0}}, 1'b1}) != '0)));

   // R5: pointer lands just past the serviced channel
   a_r5_ptr_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (start && any_req) |=> (int'(ptr_q) == wrap_inc(int'(grant_id_o), N_CH)));

   // R7: empty acknowledge returns the empty vector and keeps the pointer
   a_r7_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !any_req) |=> (!grant_vld_o && vec_o == EMPTY_VEC && $stable(ptr_q)));

   // R3: pointer only moves on a start edge
   a_r3_ptr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(ptr_q));

endmodule

// File: tb/irq_vec_arbiter_tb.sv
`timescale 1ns/1ps
module irq_vec_arbiter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq_req_i = '0;
   logic [31:0] vec_i = '0;
   logic        ack_i = 1'b0;
   logic        irq_o;
   logic [7:0]  vec_o;
   logic [1:0]  grant_id_o;
   logic        grant_vld_o;

   int total = 0;
   int bad = 0;
   int mptr = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irq_vec_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .vec_i(vec_i), .ack_i(ack_i),
      .irq_o(irq_o), .vec_o(vec_o), .grant_id_o(grant_id_o), .grant_vld_o(grant_vld_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] vec_of(input int ch, input int seed);
      return 8'((seed * 37 + ch * 29 + 5) & 8'h7F);
   endfunction

   // one acknowledge cycle; returns the granted channel (-1 when empty)
   task automatic do_ack(input logic [3:0] req, input int seed, output int got);
      int exp_id;
      logic [31:0] v;
      exp_id = -1;
      for (int k = 3; k >= 0; k--)
         if (req[(mptr + k) % 4]) exp_id = (mptr + k) % 4;
      for (int k = 0; k < 4; k++) v[k*8 +: 8] = vec_of(k, seed);
      @(negedge clk);
      irq_req_i = req;
      vec_i = v;
      #1 chk("R1 irq_o", int'(irq_o), int'(|req));
      @(negedge clk);
      ack_i = 1'b1;
      @(negedge clk);
      if (exp_id >= 0) begin
         chk("R4 grant_vld", int'(grant_vld_o), 1);
         chk("R4 grant_id", int'(grant_id_o), exp_id);
         chk("R6 vec", int'(vec_o), int'(v[exp_id*8 +: 8]));
         mptr = (exp_id + 1) % 4;
      end else begin
         chk("R7 grant_vld", int'(grant_vld_o), 0);
         chk("R7 vec", int'(vec_o), 8'hFF);
      end
      // R9: disturb inputs while acknowledge stays high
      irq_req_i = ~req;
      vec_i = ~v;
      @(negedge clk);
      @(negedge clk);
      if (exp_id >= 0) begin
         chk("R9 held id", int'(grant_id_o), exp_id);
         chk("R3 held vec", int'(vec_o), int'(v[exp_id*8 +: 8]));
      end else begin
         chk("R9 held vec", int'(vec_o), 8'hFF);
      end
      ack_i = 1'b0;
      irq_req_i = '0;
      got = exp_id;
   endtask

   initial begin
      int got;
      int prev;
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2 vld", int'(grant_vld_o), 0);
      chk("R2 id", int'(grant_id_o), 0);
      chk("R2 vec", int'(vec_o), 8'hFF);
      rst_n = 1'b1;
      // R2: channel 0 first after reset
      do_ack(4'hF, 1, got);
      chk("R2 first grant", got, 0);
      // R4 R5 R6 R7: sweep all request patterns over the reached pointer states
      for (int round = 0; round < 6; round++) begin
         for (int p = 0; p < 16; p++) begin
            do_ack(4'((p * 7 + round * 3) % 16), round * 16 + p, got);
         end
      end
      // R7: empty acknowledge leaves the pointer: next full request grants mptr
      prev = mptr;
      do_ack(4'h0, 200, got);
      do_ack(4'hF, 201, got);
      chk("R7 ptr kept", got, prev);
      // R8: continuous requests rotate in strict order
      prev = got;
      for (int i = 0; i < 8; i++) begin
         do_ack(4'hF, 300 + i, got);
         chk("R8 order", got, (prev + 1) % 4);
         prev = got;
      end
      // R5: serviced channel becomes lowest priority
      do_ack(4'b0011, 400, got);
      prev = got;
      do_ack(4'b0011, 401, got);
      chk("R5 other wins", got, prev ^ 1);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule